// File: doc/BRIEF.md
# Register-Mapped Multiply-Accumulate Unit

This block is a 16x16 multiplier peripheral with a 48-bit accumulator. A host processor reaches it through a small register file on a plain address/data bus. One 8-bit control register selects the operation, the signed or unsigned interpretation and the launch rule. Two operand registers feed the multiplier. The accumulator is read and written as three 16-bit slices. Two read-only slices hold the raw 32-bit product of the most recent operation.

An operation is launched by a write to an operand register; there is no start strobe. The result is in place on the clock edge that takes the launching write, so the next bus access already reads it. The supported operations are load, add and subtract of the product to or from the accumulator, and a signed negated load. A squaring shortcut and a clear control are also provided. A sticky flag records 48-bit overflow.

The bus has no valid/ready handshake and no back-pressure. Every write completes on the edge where `bus_wr` is high. Reads are combinational from `bus_addr`. Since the unit never stalls, no data flow through it needs flow control.

Top module: `rmac_unit`

## Requirements
- R1: After reset every mapped register reads 0000h.
- R2: The address map is fixed: 00h control, 01h operand A, 02h operand B, 03h/04h/05h accumulator bits 47:32/31:16/15:0, 0Bh/0Ch last product bits 31:16/15:0. Any other address reads 0000h, and writes to 0Bh/0Ch are ignored.
- R3: Control bits are: 7 overflow flag (read-only, writes ignored), 6 product-only, 5 clear, 4 square, 3 launch-on-any-write, 2:1 operation code, 0 unsigned. Writing the register with bit 5 set zeroes both operands and the accumulator in that cycle, and bit 5 always reads back 0.
- R4: With bits 4 and 3 clear, an operation launches on the operand write that completes the pair A and B since the last launch or control write. A lone operand write launches nothing. The result is readable on the cycle after the launching write.
- R5: With bit 3 set and bit 4 clear, a write to either operand launches an operation using the stored value of the other operand.
- R6: With bit 4 set, a write to operand A launches A times A, and writes to operand B launch nothing.
- R7: Operation code 00 loads the product, 01 adds it to the accumulator and 10 subtracts it. Code 11 loads the negated product in signed mode and acts as 00 in unsigned mode.
- R8: Bit 0 = 1 treats operands and accumulator as unsigned. Bit 0 = 0 treats them as two's complement, and the product is sign-extended to 48 bits.
- R9: With bit 6 set, an operation updates only the last-product registers and leaves the accumulator and the overflow flag unchanged.
- R10: Every operation stores the low 32 bits of the raw product in the last-product registers. Nothing else changes them.
- R11: The overflow flag sets when an add or subtract result falls outside the 48-bit range (unsigned or signed per bit 0). It stays set until the next control write, which clears it.
- R12: With control 21h, operands 1234h and 0055h give accumulator slices 0000h, 0006h, 0B44h.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write enable for the addressed register |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr` (combinational) |

## Verification
The arithmetic is driven with mixed-sign operand pairs under both interpretation bits. The same bit pattern must give a sign-extended result in one case and a zero-extended result in the other. Each operation code is applied to a known nonzero accumulator, which separates add, subtract, load and negate. Operand write orders are replayed under each launch rule, so that a lone write, a completed pair, either-operand launch and the square shortcut each show a different accumulator value. Accumulators preloaded at the unsigned and signed extremes check the overflow flag, its stickiness and its clearing.

// File: rtl/rmac_pkg.sv
package rmac_pkg;

  typedef enum logic [1:0] {
    OP_LOAD = 2'b00,
    OP_ADD  = 2'b01,
    OP_SUB  = 2'b10,
    OP_NEG  = 2'b11
  } op_e;

  // Control register image, bit 7 down to bit 0.
  typedef struct packed {
    logic ovf;        // sticky overflow, read-only
    logic prod_only;  // result goes to last-product registers only
    logic clr;        // clear strobe, never stored as 1
    logic sq;         // square shortcut
    logic any_trig;   // launch on any operand write
    op_e  op;         // operation code
    logic uns;        // 1 = unsigned
  } ctl_t;

  localparam int unsigned A_CTL     = 0;
  localparam int unsigned A_OPA     = 1;
  localparam int unsigned A_OPB     = 2;
  localparam int unsigned A_ACC_LO  = 5;   // slice k at A_ACC_LO - k
  localparam int unsigned A_PROD_LO = 12;  // slice k at A_PROD_LO - k

endpackage

// File: rtl/rmac_trig.sv
module rmac_trig (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_a,
  input  logic wr_b,
  input  logic wr_ctl,
  input  logic sq,
  input  logic any_trig,
  output logic go
);

  logic a_seen_q;
  logic b_seen_q;

  always_comb begin
    if (sq) begin
      go = wr_a;
    end else if (any_trig) begin
      go = wr_a | wr_b;
    end else begin
      go = (wr_a & b_seen_q) | (wr_b & a_seen_q);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_seen_q <= 1'b0;
      b_seen_q <= 1'b0;
    end else if (wr_ctl || go) begin
      a_seen_q <= 1'b0;
      b_seen_q <= 1'b0;
    end else begin
      if (wr_a) a_seen_q <= 1'b1;
      if (wr_b) b_seen_q <= 1'b1;
    end
  end

endmodule

// File: rtl/rmac_arith.sv
module rmac_arith
  import rmac_pkg::*;
#(
  parameter int unsigned OPW = 16
) (
  input  logic [OPW-1:0]   a,
  input  logic [OPW-1:0]   b,
  input  logic             uns,
  input  op_e              op,
  input  logic [3*OPW-1:0] acc,
  output logic [2*OPW-1:0] prod,
  output logic [3*OPW-1:0] acc_nxt,
  output logic             ovf_hit
);

  localparam int unsigned PW  = 2 * OPW;
  localparam int unsigned AW  = 3 * OPW;
  localparam int unsigned FW  = 2 * OPW + 2;   // full signed product width
  localparam int unsigned PAD = AW + 1 - FW;

  logic signed [OPW:0]  ax;
  logic signed [OPW:0]  bx;
  logic signed [FW-1:0] pfull;
  logic [AW:0]          pe;
  logic [AW:0]          ae;
  logic [AW:0]          r;

  // One extra operand bit makes a single signed multiplier serve both modes.
  assign ax    = {~uns & a[OPW-1], a};
  assign bx    = {~uns & b[OPW-1], b};
  assign pfull = ax * bx;
  assign prod  = pfull[PW-1:0];
  assign pe    = {{PAD{pfull[FW-1]}}, pfull};
  assign ae    = {~uns & acc[AW-1], acc};

  always_comb begin
    case (op)
      OP_ADD:  r = ae + pe;
      OP_SUB:  r = ae - pe;
      OP_NEG:  r = uns ? pe : (~pe + 1'b1);
      default: r = pe;
    endcase
  end

  assign acc_nxt = r[AW-1:0];

  always_comb begin
    if (op == OP_ADD || op == OP_SUB) begin
      ovf_hit = uns ? r[AW] : (r[AW] ^ r[AW-1]);
    end else begin
      ovf_hit = 1'b0;
    end
  end

endmodule

// File: rtl/rmac_rdmux.sv
module rmac_rdmux
  import rmac_pkg::*;
#(
  parameter int unsigned OPW    = 16,
  parameter int unsigned ADDR_W = 4
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        ctl_img,
  input  logic [3*OPW-1:0]  acc,
  input  logic [2*OPW-1:0]  prod,
  output logic [OPW-1:0]    rdata
);

  localparam int unsigned NACC  = 3;
  localparam int unsigned NPROD = 2;

  logic [OPW-1:0] acc_part  [NACC];
  logic [OPW-1:0] prod_part [NPROD];

  for (genvar g = 0; g < NACC; g++) begin : g_acc
    assign acc_part[g] = (addr == ADDR_W'(A_ACC_LO - g)) ? acc[g*OPW +: OPW] : '0;
  end

  for (genvar g = 0; g < NPROD; g++) begin : g_prod
    assign prod_part[g] = (addr == ADDR_W'(A_PROD_LO - g)) ? prod[g*OPW +: OPW] : '0;
  end

  always_comb begin
    rdata = (addr == ADDR_W'(A_CTL)) ? OPW'(ctl_img) : '0;
    for (int k = 0; k < NACC; k++)  rdata = rdata | acc_part[k];
    for (int k = 0; k < NPROD; k++) rdata = rdata | prod_part[k];
  end

endmodule

// File: rtl/rmac_unit.sv
module rmac_unit
  import rmac_pkg::*;
#(
  parameter int unsigned OPW    = 16,
  parameter int unsigned ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [OPW-1:0]    bus_wdata,
  output logic [OPW-1:0]    bus_rdata
);

  localparam int unsigned AW   = 3 * OPW;
  localparam int unsigned PW   = 2 * OPW;
  localparam int unsigned NACC = 3;

  ctl_t           ctl_q;
  logic [OPW-1:0] opa_q;
  logic [OPW-1:0] opb_q;
  logic [AW-1:0]  acc_q;
  logic [PW-1:0]  prod_q;

  logic            wr_ctl;
  logic            wr_a;
  logic            wr_b;
  logic [NACC-1:0] wr_acc;
  logic            go;
  logic [OPW-1:0]  a_in;
  logic [OPW-1:0]  b_in;
  logic [PW-1:0]   prod;
  logic [AW-1:0]   acc_nxt;
  logic            ovf_hit;

  assign wr_ctl = bus_wr && (bus_addr == ADDR_W'(A_CTL));
  assign wr_a   = bus_wr && (bus_addr == ADDR_W'(A_OPA));
  assign wr_b   = bus_wr && (bus_addr == ADDR_W'(A_OPB));

  always_comb begin
    for (int k = 0; k < NACC; k++) begin
      wr_acc[k] = bus_wr && (bus_addr == ADDR_W'(A_ACC_LO - k));
    end
  end

  // Operands as seen by the multiplier in the launching cycle.
  assign a_in = wr_a ? bus_wdata : opa_q;
  assign b_in = ctl_q.sq ? a_in : (wr_b ? bus_wdata : opb_q);

  rmac_trig trig_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_a     (wr_a),
    .wr_b     (wr_b),
    .wr_ctl   (wr_ctl),
    .sq       (ctl_q.sq),
    .any_trig (ctl_q.any_trig),
    .go       (go)
  );

  rmac_arith #(.OPW(OPW)) arith_i (
    .a       (a_in),
    .b       (b_in),
    .uns     (ctl_q.uns),
    .op      (ctl_q.op),
    .acc     (acc_q),
    .prod    (prod),
    .acc_nxt (acc_nxt),
    .ovf_hit (ovf_hit)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q  <= '0;
      opa_q  <= '0;
      opb_q  <= '0;
      acc_q  <= '0;
      prod_q <= '0;
    end else begin
      if (wr_ctl) begin
        ctl_q.ovf       <= 1'b0;
        ctl_q.prod_only <= bus_wdata[6];
        ctl_q.clr       <= 1'b0;
        ctl_q.sq        <= bus_wdata[4];
        ctl_q.any_trig  <= bus_wdata[3];
        ctl_q.op        <= op_e'(bus_wdata[2:1]);
        ctl_q.uns       <= bus_wdata[0];
        if (bus_wdata[5]) begin
          opa_q <= '0;
          opb_q <= '0;
          acc_q <= '0;
        end
      end
      if (wr_a) opa_q <= bus_wdata;
      if (wr_b) opb_q <= bus_wdata;
      for (int k = 0; k < NACC; k++) begin
        if (wr_acc[k]) acc_q[k*OPW +: OPW] <= bus_wdata;
      end
      if (go) begin
        prod_q <= prod;
        if (!ctl_q.prod_only) begin
          acc_q <= acc_nxt;
          if (ovf_hit) ctl_q.ovf <= 1'b1;
        end
      end
    end
  end

  rmac_rdmux #(.OPW(OPW), .ADDR_W(ADDR_W)) rdmux_i (
    .addr    (bus_addr),
    .ctl_img (ctl_q),
    .acc     (acc_q),
    .prod    (prod_q),
    .rdata   (bus_rdata)
  );

endmodule

// File: rtl/rmac_unit_chk.sv
module rmac_unit_chk
  import rmac_pkg::*;
#(
  parameter int unsigned OPW    = 16,
  parameter int unsigned ADDR_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [OPW-1:0]    bus_wdata,
  input logic              go,
  input logic              ovf,
  input logic              prod_only,
  input logic [3*OPW-1:0]  acc_q,
  input logic [OPW-1:0]    opa_q,
  input logic [OPW-1:0]    opb_q,
  input logic [2*OPW-1:0]  prod_q
);

  logic ctl_wr;
  assign ctl_wr = bus_wr && (bus_addr == ADDR_W'(A_CTL));

  // R3
  clr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && bus_wdata[5]) |=> (acc_q == '0 && opa_q == '0 && opb_q == '0));

  // R11
  ovf_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_wr |=> !ovf);

  // R11
  ovf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf && !ctl_wr) |=> ovf);

  // R10
  prod_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !go |=> $stable(prod_q));

  // R9
  prod_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (go && prod_only) |=> $stable(acc_q));

  // R4
  no_go_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_wr |-> !go);

endmodule

bind rmac_unit rmac_unit_chk #(.OPW(OPW), .ADDR_W(ADDR_W)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_wr    (bus_wr),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .go        (go),
  .ovf       (ctl_q.ovf),
  .prod_only (ctl_q.prod_only),
  .acc_q     (acc_q),
  .opa_q     (opa_q),
  .opb_q     (opb_q),
  .prod_q    (prod_q)
);

// File: tb/rmac_unit_tb_top.sv
module rmac_unit_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  rmac_unit dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata)
  );

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic rchk(input string tag, input logic [3:0] a, input logic [15:0] exp);
    @(negedge clk);
    bus_wr = 1'b0; bus_addr = a;
    #1;
    chk(tag, bus_rdata, exp);
  endtask

  task automatic acc_chk(input string tag, input logic [15:0] h, input logic [15:0] m,
                         input logic [15:0] l);
    rchk({tag, " acc47_32"}, 4'h3, h);
    rchk({tag, " acc31_16"}, 4'h4, m);
    rchk({tag, " acc15_0"},  4'h5, l);
  endtask

  task automatic t_reset();
    rchk("R1 ctl", 4'h0, 16'h0);
    acc_chk("R1", 16'h0, 16'h0, 16'h0);
    rchk("R1 prod hi", 4'hB, 16'h0);
    rchk("R1 prod lo", 4'hC, 16'h0);
    rchk("R2 unmapped 06", 4'h6, 16'h0);
  endtask

  task automatic t_example();
    wr(4'h0, 16'h0021);
    rchk("R3 clr reads 0", 4'h0, 16'h0001);
    wr(4'h1, 16'h1234);
    acc_chk("R4 lone A write", 16'h0, 16'h0, 16'h0);
    wr(4'h2, 16'h0055);
    acc_chk("R12", 16'h0000, 16'h0006, 16'h0B44);
    rchk("R10 prod hi", 4'hB, 16'h0006);
    rchk("R10 prod lo", 4'hC, 16'h0B44);
  endtask

  task automatic t_accum();
    wr(4'h0, 16'h0003);
    wr(4'h1, 16'h0002); wr(4'h2, 16'h0003);
    acc_chk("R7 add", 16'h0000, 16'h0006, 16'h0B4A);
    wr(4'h0, 16'h0005);
    wr(4'h2, 16'h000A); wr(4'h1, 16'h0001);
    acc_chk("R7 sub B-then-A R4", 16'h0000, 16'h0006, 16'h0B40);
  endtask

  task automatic t_sign();
    wr(4'h0, 16'h0020);
    wr(4'h1, 16'hFFFE); wr(4'h2, 16'h0003);
    acc_chk("R8 signed", 16'hFFFF, 16'hFFFF, 16'hFFFA);
    rchk("R8 signed prod hi", 4'hB, 16'hFFFF);
    wr(4'h0, 16'h0021);
    wr(4'h1, 16'hFFFE); wr(4'h2, 16'h0003);
    acc_chk("R8 unsigned", 16'h0000, 16'h0002, 16'hFFFA);
    rchk("R10 unsigned prod hi", 4'hB, 16'h0002);
  endtask

  task automatic t_negate();
    wr(4'h0, 16'h0026);
    wr(4'h1, 16'h0010); wr(4'h2, 16'h0003);
    acc_chk("R7 negate", 16'hFFFF, 16'hFFFF, 16'hFFD0);
    wr(4'h0, 16'h0027);
    wr(4'h1, 16'h0010); wr(4'h2, 16'h0003);
    acc_chk("R7 code11 unsigned", 16'h0000, 16'h0000, 16'h0030);
  endtask

  task automatic t_any();
    wr(4'h0, 16'h0020);
    wr(4'h1, 16'h0004);
    wr(4'h0, 16'h0008);
    wr(4'h2, 16'h0005);
    acc_chk("R5 B write launches", 16'h0, 16'h0, 16'h0014);
    wr(4'h1, 16'h0003);
    acc_chk("R5 A write launches", 16'h0, 16'h0, 16'h000F);
  endtask

  task automatic t_square();
    wr(4'h0, 16'h0030);
    acc_chk("R3 clear", 16'h0, 16'h0, 16'h0);
    wr(4'h2, 16'h0009);
    acc_chk("R6 B write idle", 16'h0, 16'h0, 16'h0);
    wr(4'h1, 16'hFFFD);
    acc_chk("R6 square", 16'h0, 16'h0, 16'h0009);
    wr(4'h2, 16'h0002);
    acc_chk("R6 later B write idle", 16'h0, 16'h0, 16'h0009);
  endtask

  task automatic t_prod_only();
    wr(4'h0, 16'h0020);
    wr(4'h1, 16'h0002); wr(4'h2, 16'h0003);
    wr(4'h0, 16'h0040);
    rchk("R3 ctl readback", 4'h0, 16'h0040);
    wr(4'h1, 16'h0004); wr(4'h2, 16'h0005);
    rchk("R9 prod lo", 4'hC, 16'h0014);
    acc_chk("R9 acc kept", 16'h0, 16'h0, 16'h0006);
  endtask

  task automatic t_ovf();
    wr(4'h0, 16'h0003);
    wr(4'h3, 16'hFFFF); wr(4'h4, 16'hFFFF); wr(4'h5, 16'hFFFF);
    wr(4'h1, 16'h0001); wr(4'h2, 16'h0001);
    acc_chk("R11 unsigned wrap", 16'h0, 16'h0, 16'h0);
    rchk("R11 unsigned ovf", 4'h0, 16'h0083);
    wr(4'h1, 16'h0001); wr(4'h2, 16'h0001);
    rchk("R11 sticky", 4'h0, 16'h0083);
    wr(4'h0, 16'h0003);
    rchk("R11 cleared", 4'h0, 16'h0003);
    wr(4'h0, 16'h0002);
    wr(4'h3, 16'h7FFF); wr(4'h4, 16'hFFFF); wr(4'h5, 16'hFFFF);
    wr(4'h1, 16'h0001); wr(4'h2, 16'h0001);
    rchk("R11 signed ovf", 4'h0, 16'h0082);
    rchk("R11 signed acc", 4'h3, 16'h8000);
    wr(4'h0, 16'h0025);
    wr(4'h1, 16'h0001); wr(4'h2, 16'h0001);
    acc_chk("R11 borrow", 16'hFFFF, 16'hFFFF, 16'hFFFF);
    rchk("R11 borrow ovf", 4'h0, 16'h0085);
    wr(4'h0, 16'h0080);
    rchk("R3 ovf bit not writable", 4'h0, 16'h0000);
  endtask

  task automatic t_map();
    wr(4'h0, 16'h0021);
    wr(4'h1, 16'h0100); wr(4'h2, 16'h0100);
    wr(4'hB, 16'h1234);
    wr(4'hC, 16'h5678);
    rchk("R2 prod hi read-only", 4'hB, 16'h0001);
    rchk("R2 prod lo read-only", 4'hC, 16'h0000);
    rchk("R2 unmapped 0F", 4'hF, 16'h0000);
    rchk("R2 operand reg not readable", 4'h1, 16'h0000);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_example();
    t_accum();
    t_sign();
    t_negate();
    t_any();
    t_square();
    t_prod_only();
    t_ovf();
    t_map();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule